// File: doc/BRIEF.md
# IDE Command Window Timing Controller

This block sits behind the eight-byte command register window of an IDE channel. In its normal state every host access is forwarded to the drive-side ATA task-file registers: the read and write strobes pass through and read data comes back from the drive side. When the host issues a particular series of accesses to live task-file offsets, the window switches into control mode. In control mode the same offsets reach a small bank of chipset timing registers, and nothing is forwarded to the drive.

The block keeps two per-drive timing sets. Each set holds a read-cycle value and a write-cycle value. A single address-setup value is shared by both drives. Software selects a drive, loads that drive's timing values into staging registers, and then writes a commit key. Only the commit copies the staged values to the exported timing outputs. A relock key returns the window to normal decoding. The host bus is synchronous and carries at most one strobe per cycle. The block does not generate ATA bus waveforms; it only exports the timing values.

Top module: `ide_win_top`

## Requirements
- R1: After reset the window is locked and pass_en_o is 1. Both drive slots export read and write timing 0x59, and addr_tim_o is 0x30.
- R2: The window enters control mode on the edge of a byte write (word_i=0) of 0x03 at offset 2, when that write follows at least two consecutive word reads (word_i=1) at offset 1. A third or later consecutive read keeps the sequence armed.
- R3: Any other access made while locked clears the unlock sequence. Examples are a byte read at offset 1, an access to another offset, a wrong key value, and a word write at offset 2. After such an access the window stays locked.
- R4: While locked, tf_rd_o and tf_wr_o follow rd_i and wr_i, and rdata_o equals tf_rdata_i. In control mode, pass_en_o is 0, both drive strobes stay low, and reads return the control register byte zero-extended.
- R5: In control mode, a byte write of 0x83 at offset 2 relocks the window on that edge. Any other write at offset 2 is ignored and the window stays in control mode.
- R6: Control-mode map (only the low data byte is used): offset 0 is the staged read timing of the selected drive, and offset 1 is its staged write timing. Offset 3 is the control byte, which reads back as last written. Offsets 2, 4 and 7 read as 0.
- R7: A write to offset 6 takes bit 0 as the drive select and bits 7:1 as the shared address-setup value. Reading offset 6 returns {address bits 7:1, select}.
- R8: Bit 0 of offset 5 reports the bus clock (0 = 33 MHz, 1 = 25 MHz). It is latched from strap_i at the first clock edge after reset, and writes to offset 5 do not change it.
- R9: A write of 0x85 at offset 3 copies both staged sets to rd_tim_o and wr_tim_o. Drive n uses bits 8n+7:8n. The same write copies {address bits, 0} to addr_tim_o. The timing outputs change on no other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 1 | Bus clock strap, latched after reset |
| addr_i | input | 3 | Window offset |
| word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data |
| pass_en_o | output | 1 | Task-file forwarding enabled |
| tf_rd_o | output | 1 | Drive-side read strobe |
| tf_wr_o | output | 1 | Drive-side write strobe |
| tf_wdata_o | output | 16 | Drive-side write data |
| tf_rdata_i | input | 16 | Drive-side read data |
| rd_tim_o | output | 16 | Committed read timing, one byte per drive |
| wr_tim_o | output | 16 | Committed write timing, one byte per drive |
| addr_tim_o | output | 8 | Committed shared address-setup value |

## Verification
The bench uses the default parameters: two reads to arm, reset timings 0x59 and 0x30, and two drive slots. With two reads to arm, a three-read run is short enough to show that the arm count saturates, and broken runs of one or two accesses can be tried. With two slots, the bench programs both drives with different values, interleaves the select writes, and can compare them across a non-commit control value and a real commit. The bench applies a second reset with the opposite strap level, so both clock readings are checked.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;
  localparam int NUM_DEV = 2;
  localparam int TIM_W   = 8;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] OFS_RDTIM = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_WRTIM = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_KEY   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STRAP = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MISC  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_ARM   = 3'd1;

  localparam logic [7:0] KEY_UNLOCK = 8'h03;
  localparam logic [7:0] KEY_RELOCK = 8'h83;
  localparam logic [7:0] KEY_COMMIT = 8'h85;
endpackage

// File: rtl/win_unlock_seq.sv
module win_unlock_seq
  import ide_win_pkg::*;
#(
  parameter int ARM_READS = 2,
  localparam int CNT_W = $clog2(ARM_READS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wbyte_i,
  output logic              ctl_mode_o,
  output logic [CNT_W-1:0]  arm_cnt_o
);
  logic             mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             arm_rd, armed, key_wr, relock_wr;

  assign arm_rd    = rd_i & word_i & (addr_i == OFS_ARM);
  assign armed     = (cnt_q == CNT_W'(ARM_READS));
  assign key_wr    = wr_i & ~word_i & (addr_i == OFS_KEY) & (wbyte_i == KEY_UNLOCK);
  assign relock_wr = wr_i & ~word_i & (addr_i == OFS_KEY) & (wbyte_i == KEY_RELOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!mode_q) begin
      if (key_wr && armed) begin
        mode_q <= 1'b1;
        cnt_q  <= '0;
      end else if (arm_rd) begin
        cnt_q <= armed ? cnt_q : cnt_q + CNT_W'(1);
      end else if (rd_i || wr_i) begin
        cnt_q <= '0;
      end
    end else begin
      cnt_q <= '0;
      if (relock_wr) mode_q <= 1'b0;
    end
  end

  assign ctl_mode_o = mode_q;
  assign arm_cnt_o  = cnt_q;
endmodule

// File: rtl/win_tim_bank.sv
module win_tim_bank
  import ide_win_pkg::*;
#(
  parameter logic [TIM_W-1:0] RST_DATA_TIM = 8'h59,
  parameter logic [TIM_W-1:0] RST_ADDR_TIM = 8'h30,
  localparam int SEL_W = $clog2(NUM_DEV)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ld_rd_i,
  input  logic                     ld_wr_i,
  input  logic                     ld_misc_i,
  input  logic                     commit_i,
  input  logic [7:0]               wbyte_i,
  output logic [SEL_W-1:0]         sel_o,
  output logic [7-SEL_W:0]         addr_stg_o,
  output logic [TIM_W-1:0]         stg_rd_o,
  output logic [TIM_W-1:0]         stg_wr_o,
  output logic [NUM_DEV*TIM_W-1:0] rd_tim_o,
  output logic [NUM_DEV*TIM_W-1:0] wr_tim_o,
  output logic [TIM_W-1:0]         addr_tim_o
);
  logic [SEL_W-1:0] sel_q;
  logic [7-SEL_W:0] addr_stg_q;
  logic [TIM_W-1:0] addr_out_q;
  logic [TIM_W-1:0] stg_rd [NUM_DEV];
  logic [TIM_W-1:0] stg_wr [NUM_DEV];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= '0;
      addr_stg_q <= RST_ADDR_TIM[7:SEL_W];
      addr_out_q <= RST_ADDR_TIM;
    end else begin
      if (ld_misc_i) begin
        sel_q      <= wbyte_i[SEL_W-1:0];
        addr_stg_q <= wbyte_i[7:SEL_W];
      end
      if (commit_i) addr_out_q <= {addr_stg_q, {SEL_W{1'b0}}};
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic [TIM_W-1:0] out_rd_q, out_wr_q;
    logic             hit;
    assign hit = (sel_q == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_rd[g] <= RST_DATA_TIM;
        stg_wr[g] <= RST_DATA_TIM;
        out_rd_q  <= RST_DATA_TIM;
        out_wr_q  <= RST_DATA_TIM;
      end else begin
        if (ld_rd_i && hit) stg_rd[g] <= wbyte_i;
        if (ld_wr_i && hit) stg_wr[g] <= wbyte_i;
        if (commit_i) begin
          out_rd_q <= stg_rd[g];
          out_wr_q <= stg_wr[g];
        end
      end
    end

    assign rd_tim_o[g*TIM_W +: TIM_W] = out_rd_q;
    assign wr_tim_o[g*TIM_W +: TIM_W] = out_wr_q;
  end

  assign sel_o      = sel_q;
  assign addr_stg_o = addr_stg_q;
  assign stg_rd_o   = stg_rd[sel_q];
  assign stg_wr_o   = stg_wr[sel_q];
  assign addr_tim_o = addr_out_q;
endmodule

// File: rtl/win_strap_latch.sv
module win_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic strap_o,
  output logic vld_o
);
  logic strap_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= 1'b0;
      vld_q   <= 1'b0;
    end else if (!vld_q) begin
      strap_q <= strap_i;
      vld_q   <= 1'b1;
    end
  end

  assign strap_o = strap_q;
  assign vld_o   = vld_q;
endmodule

// File: rtl/ide_win_top.sv
module ide_win_top
  import ide_win_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ARM_READS = 2,
  parameter logic [TIM_W-1:0] RST_DATA_TIM = 8'h59,
  parameter logic [TIM_W-1:0] RST_ADDR_TIM = 8'h30,
  localparam int CNT_W = $clog2(ARM_READS + 1),
  localparam int SEL_W = $clog2(NUM_DEV)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strap_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     word_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     pass_en_o,
  output logic                     tf_rd_o,
  output logic                     tf_wr_o,
  output logic [DATA_W-1:0]        tf_wdata_o,
  input  logic [DATA_W-1:0]        tf_rdata_i,
  output logic [NUM_DEV*TIM_W-1:0] rd_tim_o,
  output logic [NUM_DEV*TIM_W-1:0] wr_tim_o,
  output logic [TIM_W-1:0]         addr_tim_o
);
  logic             ctl_mode;
  logic [CNT_W-1:0] arm_cnt;
  logic             strap_q, strap_vld;
  logic [7:0]       wbyte, ctrl_q, ctl_byte;
  logic             ctl_wr, ld_rd, ld_wr, ld_misc, commit;
  logic [SEL_W-1:0] sel;
  logic [7-SEL_W:0] addr_stg;
  logic [TIM_W-1:0] stg_rd, stg_wr;

  assign wbyte = wdata_i[7:0];

  win_unlock_seq #(.ARM_READS(ARM_READS)) u_seq (
    .clk_i, .rst_ni, .rd_i, .wr_i, .word_i, .addr_i,
    .wbyte_i(wbyte), .ctl_mode_o(ctl_mode), .arm_cnt_o(arm_cnt)
  );

  win_strap_latch u_strap (
    .clk_i, .rst_ni, .strap_i, .strap_o(strap_q), .vld_o(strap_vld)
  );

  assign ctl_wr  = ctl_mode & wr_i;
  assign ld_rd   = ctl_wr & (addr_i == OFS_RDTIM);
  assign ld_wr   = ctl_wr & (addr_i == OFS_WRTIM);
  assign ld_misc = ctl_wr & (addr_i == OFS_MISC);
  assign commit  = ctl_wr & (addr_i == OFS_CTRL) & (wbyte == KEY_COMMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ctrl_q <= 8'h00;
    else if (ctl_wr && addr_i == OFS_CTRL)    ctrl_q <= wbyte;
  end

  win_tim_bank #(.RST_DATA_TIM(RST_DATA_TIM), .RST_ADDR_TIM(RST_ADDR_TIM)) u_bank (
    .clk_i, .rst_ni,
    .ld_rd_i(ld_rd), .ld_wr_i(ld_wr), .ld_misc_i(ld_misc), .commit_i(commit),
    .wbyte_i(wbyte), .sel_o(sel), .addr_stg_o(addr_stg),
    .stg_rd_o(stg_rd), .stg_wr_o(stg_wr),
    .rd_tim_o, .wr_tim_o, .addr_tim_o
  );

  always_comb begin
    ctl_byte = 8'h00;
    case (addr_i)
      OFS_RDTIM: ctl_byte = stg_rd;
      OFS_WRTIM: ctl_byte = stg_wr;
      OFS_CTRL:  ctl_byte = ctrl_q;
      OFS_STRAP: ctl_byte = {7'b0, strap_q};
      OFS_MISC:  ctl_byte = {addr_stg, sel};
      default:   ctl_byte = 8'h00;
    endcase
  end

  assign rdata_o    = ctl_mode ? {{(DATA_W-8){1'b0}}, ctl_byte} : tf_rdata_i;
  assign pass_en_o  = ~ctl_mode;
  assign tf_rd_o    = rd_i & ~ctl_mode;
  assign tf_wr_o    = wr_i & ~ctl_mode;
  assign tf_wdata_o = wdata_i;
endmodule

// File: rtl/ide_win_chk.sv
module ide_win_chk
  import ide_win_pkg::*;
#(
  parameter int ARM_READS = 2,
  localparam int CNT_W = $clog2(ARM_READS + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ADDR_W-1:0]        addr_i,
  input logic                     word_i,
  input logic                     rd_i,
  input logic                     wr_i,
  input logic [7:0]               wbyte_i,
  input logic                     pass_en_o,
  input logic                     tf_rd_o,
  input logic                     tf_wr_o,
  input logic [NUM_DEV*TIM_W-1:0] rd_tim_o,
  input logic [NUM_DEV*TIM_W-1:0] wr_tim_o,
  input logic [TIM_W-1:0]         addr_tim_o,
  input logic                     ctl_mode,
  input logic [CNT_W-1:0]         arm_cnt,
  input logic                     strap_q,
  input logic                     strap_vld
);
  a_r2_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_mode && arm_cnt == CNT_W'(ARM_READS) && wr_i && !word_i &&
     addr_i == OFS_KEY && wbyte_i == KEY_UNLOCK) |=> !pass_en_o);

  a_r3_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_mode && (rd_i || wr_i) && !(rd_i && word_i && addr_i == OFS_ARM))
      |=> arm_cnt == '0);

  a_r4_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_en_o |-> (!tf_rd_o && !tf_wr_o));

  a_r5_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_mode && wr_i && !word_i && addr_i == OFS_KEY && wbyte_i == KEY_RELOCK)
      |=> pass_en_o);

  a_r8_strap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_vld && $past(strap_vld)) |-> $stable(strap_q));

  a_r9_commit_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_mode && wr_i && addr_i == OFS_CTRL && wbyte_i == KEY_COMMIT)
      |=> ($stable(rd_tim_o) && $stable(wr_tim_o) && $stable(addr_tim_o)));
endmodule

bind ide_win_top ide_win_chk #(.ARM_READS(ARM_READS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .word_i(word_i),
  .rd_i(rd_i), .wr_i(wr_i), .wbyte_i(wdata_i[7:0]),
  .pass_en_o(pass_en_o), .tf_rd_o(tf_rd_o), .tf_wr_o(tf_wr_o),
  .rd_tim_o(rd_tim_o), .wr_tim_o(wr_tim_o), .addr_tim_o(addr_tim_o),
  .ctl_mode(ctl_mode), .arm_cnt(arm_cnt), .strap_q(strap_q), .strap_vld(strap_vld)
);

// File: tb/sim_ide_win_top.sv
`timescale 1ns/1ps
module sim_ide_win_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        word_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [15:0] wdata_i = '0, tf_rdata_i = '0;
  logic [15:0] rdata_o, tf_wdata_o, rd_tim_o, wr_tim_o;
  logic [7:0]  addr_tim_o;
  logic        pass_en_o, tf_rd_o, tf_wr_o;

  always #5 clk_i = ~clk_i;

  ide_win_top u0 (
    .clk_i, .rst_ni, .strap_i, .addr_i, .word_i, .rd_i, .wr_i, .wdata_i,
    .rdata_o, .pass_en_o, .tf_rd_o, .tf_wr_o, .tf_wdata_o, .tf_rdata_i,
    .rd_tim_o, .wr_tim_o, .addr_tim_o
  );

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  bit done = 1'b0;

  // reference model state
  int m_ctl, m_cnt, m_sel, m_strap, m_ctrl, m_saddr, m_oaddr;
  int m_srd[2], m_swr[2], m_ord[2], m_owr[2];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset(input int s);
    m_ctl = 0; m_cnt = 0; m_sel = 0; m_ctrl = 0; m_strap = s;
    m_saddr = 'h30; m_oaddr = 'h30;
    for (int i = 0; i < 2; i++) begin
      m_srd[i] = 'h59; m_swr[i] = 'h59; m_ord[i] = 'h59; m_owr[i] = 'h59;
    end
  endtask

  function automatic int exp_rdata(input int a, input int tfr);
    if (m_ctl == 0) return tfr;
    case (a)
      0: return m_srd[m_sel];
      1: return m_swr[m_sel];
      3: return m_ctrl;
      5: return m_strap;
      6: return m_saddr | m_sel;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(input bit rd, input bit wr, input bit wd, input int a, input int d);
    int wb;
    wb = d & 'hFF;
    if (m_ctl == 0) begin
      if (wr && !wd && a == 2 && wb == 'h03 && m_cnt >= 2) begin
        m_ctl = 1; m_cnt = 0;
      end else if (rd && wd && a == 1) begin
        m_cnt = (m_cnt >= 2) ? 2 : m_cnt + 1;
      end else if (rd || wr) begin
        m_cnt = 0;
      end
    end else if (wr) begin
      case (a)
        0: m_srd[m_sel] = wb;
        1: m_swr[m_sel] = wb;
        2: if (!wd && wb == 'h83) m_ctl = 0;
        3: begin
          m_ctrl = wb;
          if (wb == 'h85) begin
            for (int i = 0; i < 2; i++) begin
              m_ord[i] = m_srd[i]; m_owr[i] = m_swr[i];
            end
            m_oaddr = m_saddr;
          end
        end
        6: begin m_sel = wb & 1; m_saddr = wb & 'hFE; end
        default: ;
      endcase
    end
  endtask

  // one bus cycle; outputs compared against the model before the edge
  task automatic cyc(input string tag, input bit rd, input bit wr, input bit wd,
                     input int a, input int d);
    int tfr;
    tfr = (16'hC0DE ^ (n_cyc * 37)) & 'hFFFF;
    n_cyc++;
    rd_i = rd; wr_i = wr; word_i = wd; addr_i = 3'(a); wdata_i = 16'(d);
    tf_rdata_i = 16'(tfr);
    #3;
    if (rd) chk(tag, int'(rdata_o), exp_rdata(a, tfr));
    chk("R4 pass_en", int'(pass_en_o), (m_ctl == 0) ? 1 : 0);
    chk("R4 tf_rd", int'(tf_rd_o), (rd && m_ctl == 0) ? 1 : 0);
    chk("R4 tf_wr", int'(tf_wr_o), (wr && m_ctl == 0) ? 1 : 0);
    chk("R9 rd_tim", int'(rd_tim_o), (m_ord[1] << 8) | m_ord[0]);
    chk("R9 wr_tim", int'(wr_tim_o), (m_owr[1] << 8) | m_owr[0]);
    chk("R9 addr_tim", int'(addr_tim_o), m_oaddr);
    @(posedge clk_i);
    model_step(rd, wr, wd, a, d);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc("R4", 1'b0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic rd_w1(input string tag);
    cyc(tag, 1'b1, 1'b0, 1'b1, 1, 0);
  endtask

  task automatic do_reset(input bit s);
    rd_i = 0; wr_i = 0; strap_i = s;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset(int'(s));
  endtask

  task automatic unlock();
    rd_w1("R2"); rd_w1("R2");
    cyc("R2", 1'b0, 1'b1, 1'b0, 2, 'h03);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    idle(2);
    // R1: reset state
    chk("R1 pass_en", int'(pass_en_o), 1);
    chk("R1 rd_tim", int'(rd_tim_o), 'h5959);
    chk("R1 wr_tim", int'(wr_tim_o), 'h5959);
    chk("R1 addr_tim", int'(addr_tim_o), 'h30);

    // R4: pass-through while locked
    cyc("R4", 1'b1, 1'b0, 1'b1, 4, 0);
    cyc("R4", 1'b0, 1'b1, 1'b0, 7, 'h1234);
    chk("R4 tf_wdata", int'(tf_wdata_o), 'h1234);

    // R3: broken unlock patterns
    rd_w1("R3"); cyc("R3", 1'b1, 1'b0, 1'b0, 1, 0); rd_w1("R3");
    cyc("R3", 1'b0, 1'b1, 1'b0, 2, 'h03);
    chk("R3 byte read breaks", int'(pass_en_o), 1);
    rd_w1("R3"); rd_w1("R3"); cyc("R3", 1'b1, 1'b0, 1'b1, 0, 0);
    cyc("R3", 1'b0, 1'b1, 1'b0, 2, 'h03);
    chk("R3 other offset breaks", int'(pass_en_o), 1);
    rd_w1("R3"); rd_w1("R3"); cyc("R3", 1'b0, 1'b1, 1'b0, 2, 'h04);
    cyc("R3", 1'b0, 1'b1, 1'b0, 2, 'h03);
    chk("R3 wrong key breaks", int'(pass_en_o), 1);
    rd_w1("R3"); rd_w1("R3"); cyc("R3", 1'b0, 1'b1, 1'b1, 2, 'h0003);
    chk("R3 word write no unlock", int'(pass_en_o), 1);

    // R2: three reads then key
    rd_w1("R2"); rd_w1("R2"); rd_w1("R2");
    cyc("R2", 1'b0, 1'b1, 1'b0, 2, 'h03);
    chk("R2 unlocked", int'(pass_en_o), 0);

    // R4/R8: control mode reads, strap
    cyc("R8", 1'b1, 1'b0, 1'b0, 5, 0);
    cyc("R8", 1'b0, 1'b1, 1'b0, 5, 'hFE);
    cyc("R8", 1'b1, 1'b0, 1'b1, 5, 0);
    cyc("R6", 1'b1, 1'b0, 1'b1, 4, 0);
    cyc("R6", 1'b1, 1'b0, 1'b0, 2, 0);

    // R6/R7: program drive 0 then drive 1
    cyc("R7", 1'b0, 1'b1, 1'b0, 6, 'h20);
    cyc("R6", 1'b0, 1'b1, 1'b0, 0, 'h46);
    cyc("R6", 1'b0, 1'b1, 1'b1, 1, 'hAB32);
    cyc("R6", 1'b1, 1'b0, 1'b0, 0, 0);
    cyc("R7", 1'b0, 1'b1, 1'b0, 6, 'h11);
    cyc("R7", 1'b1, 1'b0, 1'b0, 6, 0);
    cyc("R6", 1'b0, 1'b1, 1'b0, 0, 'h20);
    cyc("R6", 1'b0, 1'b1, 1'b0, 1, 'h10);
    cyc("R6", 1'b1, 1'b0, 1'b0, 1, 0);
    cyc("R6", 1'b1, 1'b0, 1'b0, 0, 0);
    chk("R9 no early update", int'(rd_tim_o), 'h5959);

    // R9: non-commit control value, then commit
    cyc("R9", 1'b0, 1'b1, 1'b0, 3, 'h84);
    cyc("R6", 1'b1, 1'b0, 1'b0, 3, 0);
    chk("R9 0x84 no commit", int'(wr_tim_o), 'h5959);
    // R5: other key values ignored
    cyc("R5", 1'b0, 1'b1, 1'b0, 2, 'h55);
    cyc("R5", 1'b0, 1'b1, 1'b1, 2, 'h0083);
    chk("R5 still control", int'(pass_en_o), 0);
    cyc("R9", 1'b0, 1'b1, 1'b0, 3, 'h85);
    chk("R9 rd_tim commit", int'(rd_tim_o), 'h2046);
    chk("R9 wr_tim commit", int'(wr_tim_o), 'h1032);
    chk("R9 addr commit", int'(addr_tim_o), 'h10);
    cyc("R7", 1'b1, 1'b0, 1'b0, 6, 0);
    cyc("R7", 1'b0, 1'b1, 1'b0, 6, 'h20);
    cyc("R6", 1'b1, 1'b0, 1'b0, 1, 0);

    // R5: relock
    cyc("R5", 1'b0, 1'b1, 1'b0, 2, 'h83);
    chk("R5 relocked", int'(pass_en_o), 1);
    cyc("R4", 1'b1, 1'b0, 1'b1, 0, 0);
    cyc("R4", 1'b0, 1'b1, 1'b0, 3, 'h85);
    chk("R9 locked write no commit", int'(addr_tim_o), 'h10);

    // R8: second reset with other strap level
    do_reset(1'b0);
    idle(2);
    chk("R1 reset rd_tim", int'(rd_tim_o), 'h5959);
    unlock();
    cyc("R8", 1'b1, 1'b0, 1'b0, 5, 0);
    cyc("R5", 1'b0, 1'b1, 1'b0, 2, 'h83);
    idle(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule